// File: doc/BRIEF.md
# Frame-Delay Feedback DVFS Controller

This block picks the clock speed of a media decoder so that the average frame delay stays close to a target. For each decoded frame it receives the delay that frame saw and the number of frames waiting to be decoded. The stored history is kept in a speed-independent form: each delay is scaled to the time it would have taken at full speed. Every fifth frame the controller runs an integral control law against the average over a sliding window of recent frames. The first pass uses the stored history as it stands. Each later pass asks what the window's average delay would have been at the speed the previous pass chose, and feeds that answer back into the same law. This repeats a programmable number of times.

After the integral passes, a term proportional to the change in decode-queue depth since the last sample is added. The result is rounded up to one of 32 linear frequency steps. The voltage for that step comes from a 32-entry table that software can write. The integral law aims at a working set-point, not directly at the user set-point. A running sum of every frame's delay minus the user set-point pulls the working set-point down a notch when frames have been late overall, and up a notch when they have been early. Delays and set-points are unsigned Q8.8 seconds, and the speed factor is Q1.15. Frames are accepted at any time. A sample boundary that falls while a computation is still running is dropped.

Top module: `frame_dvfs_ctrl`

## Requirements
- R1: After reset: frequency level is 31, busy and level_valid are low, the speed factor is 1.0 (32768), the window, delay accumulator and sample counter are empty, and the queue reference is 0. Voltage entry L resets to 64 + 5·L.
- R2: A computation starts only after every fifth frame accepted since reset. Each accepted frame stores floor(delay·(L+1)/32), where L is the level in force when that frame is accepted.
- R3: Each pass computes the average a = min(65535, floor(S·32768/(N·r))), where S is the sum of the stored values, N is their count and r is the current factor. It then sets r ← clamp(r + 256·(a − w)), which is integral gain −2 with delay in seconds; w is the working set-point.
- R4: The factor is clamped to [1024, 32768]. The output level is ceil(r/1024) − 1, so the level range is 0 to 31.
- R5: The accumulator sums (delay − setpoint_i) over all frames. At each sample, w = max(0, setpoint_i − 2) if the sum is positive, min(65535, setpoint_i + 2) if it is negative, and setpoint_i if it is zero.
- R6: Each sample runs iter_cnt_i passes. A value of 0 runs one pass, and any value above 10 runs ten.
- R7: After the passes, r ← clamp(r + 256·(q − q_ref)), where q is queue_depth_i. Then q_ref takes the value of q.
- R8: The window holds at most 70 entries. Once full, each new frame replaces the oldest entry, and that entry's value leaves the sum.
- R9: volt_level_o is the table entry selected by the current level. A write through the table port changes the entry from the next cycle on.
- R10: busy_o rises the cycle after a sample trigger. level_valid_o pulses for one cycle in the cycle busy_o falls, and the level changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One decoded frame reported this cycle |
| frame_delay_i | input | 16 | Delay of that frame, Q8.8 seconds |
| queue_depth_i | input | 8 | Frames waiting in the decode queue |
| setpoint_i | input | 16 | User delay target, Q8.8 seconds |
| iter_cnt_i | input | 4 | Number of passes per sample |
| vtab_we_i | input | 1 | Voltage table write strobe |
| vtab_addr_i | input | 5 | Voltage table entry to write |
| vtab_data_i | input | 8 | Voltage code to store |
| freq_level_o | output | 5 | Selected frequency step |
| volt_level_o | output | 8 | Voltage code for the selected step |
| level_valid_o | output | 1 | One-cycle pulse when a new step is produced |
| busy_o | output | 1 | A sample computation is running |

## Verification
The bench checks every result against a model of the requirements. Frames on target confirm that the factor holds still. Light loads show the convergence that the repeated passes produce, and an abrupt swing from a huge target to a tiny one drives the factor into both clamps. Runs with one pass, zero passes, ten passes and fifteen passes separate the pass limits from the count. A queue that steps up and then holds isolates the differential term from the integral one, and a long sequence of mixed delay bands exercises window eviction and the set-point nudges. Table writes to the selected and to an unselected entry separate the voltage lookup from the level logic.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV_START, ST_DIV_WAIT, ST_DIFF} ctrl_st_e;
endpackage

// File: rtl/fdc_window.sv
module fdc_window #(
  parameter int DW     = 16,
  parameter int FW     = 16,
  parameter int DEPTH  = 70,
  parameter int PERIOD = 5,
  parameter int ACCW   = 32,
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int SUMW  = DW + CNTW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_valid_i,
  input  logic [DW-1:0]          delay_i,
  input  logic [FW-1:0]          fac_i,
  input  logic [DW-1:0]          sp_i,
  input  logic                   busy_i,
  output logic [SUMW-1:0]        wsum_o,
  output logic [CNTW-1:0]        cnt_o,
  output logic signed [ACCW-1:0] acc_o,
  output logic                   sample_o
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int PHW  = $clog2(PERIOD + 1);

  logic [DW-1:0]          mem [DEPTH];
  logic [PTRW-1:0]        wr_ptr;
  logic [CNTW-1:0]        cnt_q;
  logic [SUMW-1:0]        sum_q;
  logic signed [ACCW-1:0] acc_q;
  logic [PHW-1:0]         phase_q;
  logic                   sample_q;
  logic [DW+FW-1:0]       prod;
  logic [DW-1:0]          work, evict;
  logic                   full;

  // normalise to full-speed time: delay * factor / 2^(FW-1)
  assign prod  = {{FW{1'b0}}, delay_i} * {{DW{1'b0}}, fac_i};
  assign work  = prod[FW-1 +: DW];
  assign full  = (cnt_q == CNTW'(DEPTH));
  assign evict = full ? mem[wr_ptr] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr   <= '0;
      cnt_q    <= '0;
      sum_q    <= '0;
      acc_q    <= '0;
      phase_q  <= '0;
      sample_q <= 1'b0;
    end else begin
      sample_q <= 1'b0;
      if (frame_valid_i) begin
        mem[wr_ptr] <= work;
        wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (!full) cnt_q <= cnt_q + 1'b1;
        sum_q <= sum_q + SUMW'(work) - SUMW'(evict);
        acc_q <= acc_q + ACCW'(signed'({1'b0, delay_i})) - ACCW'(signed'({1'b0, sp_i}));
        if (phase_q == PHW'(PERIOD - 1)) begin
          phase_q  <= '0;
          sample_q <= !busy_i;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign wsum_o   = sum_q;
  assign cnt_o    = cnt_q;
  assign acc_o    = acc_q;
  assign sample_o = sample_q;

  assert_fill_grows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_fill_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && full) |=> (cnt_q == CNTW'(DEPTH)));
  assert_sample_after_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> $past(frame_valid_i));
endmodule

// File: rtl/fdc_div.sv
module fdc_div #(
  parameter int NW   = 38,
  parameter int DENW = 23
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NW-1:0]   num_i,
  input  logic [DENW-1:0] den_i,
  output logic            done_o,
  output logic [NW-1:0]   quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]   qn_q, num_q;
  logic [DENW-1:0] den_q;
  logic [DENW:0]   rem_q, rem_sh;
  logic [CW-1:0]   cnt_q;
  logic            run_q, done_q;

  assign rem_sh = {rem_q[DENW-1:0], qn_q[NW-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qn_q <= '0; num_q <= '0; den_q <= '0; rem_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        qn_q <= num_i; num_q <= num_i; den_q <= den_i;
        rem_q <= '0; cnt_q <= CW'(NW); run_q <= 1'b1;
      end else if (run_q) begin
        if (rem_sh >= {1'b0, den_q}) begin
          rem_q <= rem_sh - {1'b0, den_q};
          qn_q  <= {qn_q[NW-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          qn_q  <= {qn_q[NW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = qn_q;

  assert_div_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((64'(qn_q) * 64'(den_q) <= 64'(num_q)) &&
                ((64'(qn_q) + 64'd1) * 64'(den_q) > 64'(num_q))));
endmodule

// File: rtl/fdc_ctrl.sv
module fdc_ctrl import fdc_pkg::*; #(
  parameter int DW       = 16,
  parameter int FW       = 16,
  parameter int DFRAC    = 8,
  parameter int SUMW     = 23,
  parameter int CNTW     = 7,
  parameter int ACCW     = 32,
  parameter int QW       = 8,
  parameter int ITW      = 4,
  parameter int ITER_MAX = 10,
  parameter int KI_LOG2  = 1,
  parameter int KD_SHIFT = 8,
  parameter int SP_STEP  = 2,
  parameter int LVLW     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_i,
  input  logic [SUMW-1:0]        wsum_i,
  input  logic [CNTW-1:0]        cnt_i,
  input  logic signed [ACCW-1:0] acc_i,
  input  logic [DW-1:0]          sp_i,
  input  logic [ITW-1:0]         iter_i,
  input  logic [QW-1:0]          queue_i,
  output logic                   busy_o,
  output logic [LVLW-1:0]        level_o,
  output logic                   valid_o
);
  localparam int FRAC_F    = FW - 1;
  localparam int ONE       = 1 << FRAC_F;
  localparam int STEP_LOG2 = FRAC_F - LVLW;
  localparam int R_MIN     = 1 << STEP_LOG2;
  localparam int KI_SHIFT  = FRAC_F - DFRAC + KI_LOG2;
  localparam int NW        = SUMW + FRAC_F;
  localparam int DENW      = CNTW + FW;
  localparam int SW        = DW + FW + QW + 4;
  localparam logic signed [SW-1:0] R_MIN_S = SW'(R_MIN);
  localparam logic signed [SW-1:0] ONE_S   = SW'(ONE);
  localparam logic signed [DW+1:0] SP_MAX  = (DW+2)'((1 << DW) - 1);

  ctrl_st_e        state_q;
  logic [FW-1:0]   fac_q, r_q, r_int, r_fin;
  logic [DW-1:0]   sp_w_q, sp_adj, a_sat;
  logic [ITW-1:0]  it_q, iter_eff;
  logic [QW-1:0]   q_ref_q;
  logic [SUMW-1:0] wsum_q;
  logic [CNTW-1:0] cnt_q;
  logic [LVLW-1:0] level_q, lvl_new;
  logic            valid_q, div_done;
  logic [NW-1:0]   quo;
  logic signed [SW-1:0] r_s, err_s, dq_s;
  logic signed [DW+1:0] sp_e;
  logic [FW:0]     lvl_sum;

  function automatic logic [FW-1:0] clamp_r(input logic signed [SW-1:0] v);
    if (v < R_MIN_S) return FW'(R_MIN);
    if (v > ONE_S)   return FW'(ONE);
    return v[FW-1:0];
  endfunction

  fdc_div #(.NW(NW), .DENW(DENW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_DIV_START),
    .num_i   (NW'(wsum_q) << FRAC_F),
    .den_i   (DENW'(cnt_q) * DENW'(r_q)),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  assign a_sat = ((quo >> DW) != '0) ? '1 : quo[DW-1:0];
  assign r_s   = signed'(SW'(r_q));
  assign err_s = signed'(SW'(a_sat)) - signed'(SW'(sp_w_q));
  assign r_int = clamp_r(r_s + (err_s <<< KI_SHIFT));
  assign dq_s  = signed'(SW'(queue_i)) - signed'(SW'(q_ref_q));
  assign r_fin = clamp_r(r_s + (dq_s <<< KD_SHIFT));
  // round up to the next frequency step
  assign lvl_sum = (FW+1)'(r_fin) + (FW+1)'(R_MIN - 1);
  assign lvl_new = LVLW'((lvl_sum >> STEP_LOG2) - 1'b1);

  always_comb begin
    sp_e = signed'({2'b00, sp_i});
    if (acc_i > 0)      sp_e = (sp_e < (DW+2)'(SP_STEP)) ? '0 : sp_e - (DW+2)'(SP_STEP);
    else if (acc_i < 0) sp_e = (sp_e + (DW+2)'(SP_STEP) > SP_MAX) ? SP_MAX : sp_e + (DW+2)'(SP_STEP);
    sp_adj = sp_e[DW-1:0];
  end

  assign iter_eff = (iter_i == '0) ? ITW'(1) :
                    (iter_i > ITW'(ITER_MAX)) ? ITW'(ITER_MAX) : iter_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fac_q   <= FW'(ONE);
      r_q     <= FW'(ONE);
      sp_w_q  <= '0;
      it_q    <= '0;
      q_ref_q <= '0;
      wsum_q  <= '0;
      cnt_q   <= '0;
      level_q <= '1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (sample_i) begin
          sp_w_q  <= sp_adj;
          r_q     <= fac_q;
          it_q    <= iter_eff;
          wsum_q  <= wsum_i;
          cnt_q   <= cnt_i;
          state_q <= ST_DIV_START;
        end
        ST_DIV_START: state_q <= ST_DIV_WAIT;
        ST_DIV_WAIT: if (div_done) begin
          r_q     <= r_int;
          it_q    <= it_q - 1'b1;
          state_q <= (it_q == ITW'(1)) ? ST_DIFF : ST_DIV_START;
        end
        ST_DIFF: begin
          fac_q   <= r_fin;
          level_q <= lvl_new;
          q_ref_q <= queue_i;
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign level_o = level_q;
  assign valid_o = valid_q;

  assert_fac_bounds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fac_q >= FW'(R_MIN)) && (fac_q <= FW'(ONE)));
  assert_iter_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV_WAIT) |-> (it_q >= ITW'(1) && it_q <= ITW'(ITER_MAX)));
  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_level_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> valid_q);
  assert_busy_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_q);
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/frame_dvfs_ctrl.sv
module frame_dvfs_ctrl import fdc_pkg::*; #(
  parameter int DW       = 16,
  parameter int FW       = 16,
  parameter int QW       = 8,
  parameter int VW       = 8,
  parameter int LVLW     = 5,
  parameter int ITW      = 4,
  parameter int DEPTH    = 70,
  parameter int PERIOD   = 5,
  parameter int ITER_MAX = 10,
  parameter int KD_SHIFT = 8,
  parameter int SP_STEP  = 2,
  parameter int VBASE    = 64,
  parameter int VSTEP    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_valid_i,
  input  logic [DW-1:0]   frame_delay_i,
  input  logic [QW-1:0]   queue_depth_i,
  input  logic [DW-1:0]   setpoint_i,
  input  logic [ITW-1:0]  iter_cnt_i,
  input  logic            vtab_we_i,
  input  logic [LVLW-1:0] vtab_addr_i,
  input  logic [VW-1:0]   vtab_data_i,
  output logic [LVLW-1:0] freq_level_o,
  output logic [VW-1:0]   volt_level_o,
  output logic            level_valid_o,
  output logic            busy_o
);
  localparam int LEVELS    = 1 << LVLW;
  localparam int ACCW      = 32;
  localparam int CNTW      = $clog2(DEPTH + 1);
  localparam int SUMW      = DW + CNTW;
  localparam int STEP_LOG2 = FW - 1 - LVLW;

  logic [VW-1:0]          vtab [LEVELS];
  logic [LVLW-1:0]        level;
  logic [FW-1:0]          fac_applied;
  logic [SUMW-1:0]        wsum;
  logic [CNTW-1:0]        cnt;
  logic signed [ACCW-1:0] acc;
  logic                   sample, busy;

  assign fac_applied = FW'((LVLW+1)'(level) + 1'b1) << STEP_LOG2;

  fdc_window #(.DW(DW), .FW(FW), .DEPTH(DEPTH), .PERIOD(PERIOD), .ACCW(ACCW)) u_win (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .delay_i       (frame_delay_i),
    .fac_i         (fac_applied),
    .sp_i          (setpoint_i),
    .busy_i        (busy),
    .wsum_o        (wsum),
    .cnt_o         (cnt),
    .acc_o         (acc),
    .sample_o      (sample)
  );

  fdc_ctrl #(
    .DW(DW), .FW(FW), .DFRAC(8), .SUMW(SUMW), .CNTW(CNTW), .ACCW(ACCW), .QW(QW),
    .ITW(ITW), .ITER_MAX(ITER_MAX), .KI_LOG2(1), .KD_SHIFT(KD_SHIFT),
    .SP_STEP(SP_STEP), .LVLW(LVLW)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .wsum_i   (wsum),
    .cnt_i    (cnt),
    .acc_i    (acc),
    .sp_i     (setpoint_i),
    .iter_i   (iter_cnt_i),
    .queue_i  (queue_depth_i),
    .busy_o   (busy),
    .level_o  (level),
    .valid_o  (level_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LEVELS; i++) vtab[i] <= VW'(VBASE + i * VSTEP);
    end else if (vtab_we_i) begin
      vtab[vtab_addr_i] <= vtab_data_i;
    end
  end

  assign freq_level_o = level;
  assign volt_level_o = vtab[level];
  assign busy_o       = busy;

  assert_vtab_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtab_we_i && vtab_addr_i == level && !level_valid_o) |=> (volt_level_o == $past(vtab_data_i)));
endmodule

// File: tb/tb_frame_dvfs_ctrl.sv
module tb_frame_dvfs_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_valid = 1'b0;
  logic [15:0] frame_delay = '0;
  logic [7:0] queue = '0;
  logic [15:0] sp = 16'd26;
  logic [3:0] iter = 4'd5;
  logic       vtab_we = 1'b0;
  logic [4:0] vtab_addr = '0;
  logic [7:0] vtab_data = '0;
  logic [4:0] freq_level;
  logic [7:0] volt_level;
  logic       level_valid, busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_dvfs_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(frame_valid), .frame_delay_i(frame_delay),
    .queue_depth_i(queue), .setpoint_i(sp), .iter_cnt_i(iter), .vtab_we_i(vtab_we),
    .vtab_addr_i(vtab_addr), .vtab_data_i(vtab_data), .freq_level_o(freq_level),
    .volt_level_o(volt_level), .level_valid_o(level_valid), .busy_o(busy)
  );

  // requirement model
  longint m_win [70];
  int     m_ptr, m_cnt, m_phase, m_level, m_qref;
  longint m_sum, m_acc, m_fac;
  int     m_vtab [32];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampr(input longint v);
    if (v < 1024) return 1024;
    if (v > 32768) return 32768;
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 70; i++) m_win[i] = 0;
    m_ptr = 0; m_cnt = 0; m_phase = 0; m_level = 31; m_qref = 0;
    m_sum = 0; m_acc = 0; m_fac = 32768;
    for (int i = 0; i < 32; i++) m_vtab[i] = 64 + 5 * i;
  endtask

  task automatic m_sample(input int q);
    longint spw, r, a;
    int n;
    spw = sp;
    if (m_acc > 0) spw = (sp < 2) ? 0 : sp - 2;
    else if (m_acc < 0) spw = (sp + 2 > 65535) ? 65535 : sp + 2;
    n = (iter == 0) ? 1 : (iter > 10) ? 10 : int'(iter);
    r = m_fac;
    for (int k = 0; k < n; k++) begin
      a = (m_sum * 32768) / (longint'(m_cnt) * r);
      if (a > 65535) a = 65535;
      r = clampr(r + (a - spw) * 256);
    end
    r = clampr(r + longint'(q - m_qref) * 256);
    m_fac = r;
    m_level = int'((r + 1023) / 1024) - 1;
    m_qref = q;
  endtask

  task automatic m_frame(input int d, input int q, output bit smp);
    longint work;
    work = (longint'(d) * (m_level + 1) * 1024) / 32768;
    if (m_cnt == 70) m_sum -= m_win[m_ptr]; else m_cnt++;
    m_win[m_ptr] = work;
    m_sum += work;
    m_ptr = (m_ptr + 1) % 70;
    m_acc += d - sp;
    m_phase++;
    smp = 0;
    if (m_phase == 5) begin
      m_phase = 0;
      smp = 1;
      m_sample(q);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_valid = 1'b0;
    vtab_we = 1'b0;
    queue = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_result(input string tag);
    int n = 0;
    while (!level_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!level_valid) chk({tag, " R10 result"}, 0, 1);
  endtask

  task automatic send_frame(input int d, input int q, input string tag);
    bit smp;
    @(negedge clk);
    frame_delay = 16'(d);
    queue = 8'(q);
    frame_valid = 1'b1;
    m_frame(d, q, smp);
    @(negedge clk);
    frame_valid = 1'b0;
    if (smp) begin
      wait_result(tag);
      chk({tag, " level"}, freq_level, m_level);
      chk({tag, " R9 volt"}, volt_level, m_vtab[m_level]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 level", freq_level, 31);
    chk("R1 volt", volt_level, 219);
    chk("R1 busy", busy, 0);
    chk("R1 valid", level_valid, 0);
  endtask

  task automatic t_on_target();
    do_reset();
    sp = 16'd26; iter = 4'd5;
    for (int i = 0; i < 5; i++) send_frame(26, 0, "R3 on-target");
    chk("R3 on-target stays full", freq_level, 31);
  endtask

  task automatic t_light();
    do_reset();
    sp = 16'd26; iter = 4'd5;
    for (int i = 0; i < 15; i++) send_frame(6, 0, "R3 R5 light");
    chk("R3 light slows down", (freq_level < 31) ? 1 : 0, 1);
    for (int i = 0; i < 15; i++) send_frame(40, 0, "R3 R5 heavy");
  endtask

  task automatic t_clamp();
    do_reset();
    iter = 4'd5;
    sp = 16'd65000;
    for (int i = 0; i < 5; i++) send_frame(1, 0, "R4 low");
    chk("R4 low clamp level", freq_level, 0);
    chk("R4 low clamp volt", volt_level, 64);
    sp = 16'd2;
    for (int i = 0; i < 5; i++) send_frame(250, 0, "R4 high");
    chk("R4 high clamp level", freq_level, 31);
  endtask

  task automatic t_iter();
    int lv1, lv10;
    do_reset(); sp = 16'd26; iter = 4'd1;
    for (int i = 0; i < 5; i++) send_frame(6, 0, "R6 one pass");
    lv1 = freq_level;
    do_reset(); sp = 16'd26; iter = 4'd0;
    for (int i = 0; i < 5; i++) send_frame(6, 0, "R6 zero passes");
    chk("R6 zero runs one", freq_level, lv1);
    do_reset(); sp = 16'd26; iter = 4'd10;
    for (int i = 0; i < 5; i++) send_frame(6, 0, "R6 ten passes");
    lv10 = freq_level;
    do_reset(); sp = 16'd26; iter = 4'd15;
    for (int i = 0; i < 5; i++) send_frame(6, 0, "R6 fifteen passes");
    chk("R6 above limit runs ten", freq_level, lv10);
  endtask

  task automatic t_diff();
    do_reset(); sp = 16'd26; iter = 4'd2;
    for (int i = 0; i < 5; i++) send_frame(6, 0, "R7 base");
    for (int i = 0; i < 5; i++) send_frame(6, 12, "R7 queue step");
    for (int i = 0; i < 5; i++) send_frame(6, 12, "R7 queue held");
    for (int i = 0; i < 5; i++) send_frame(6, 3, "R7 queue drop");
  endtask

  task automatic t_window();
    do_reset(); sp = 16'd26; iter = 4'd3;
    for (int i = 0; i < 95; i++)
      send_frame(10 + ((i / 10) % 3) * 15, (i / 7) % 4, "R8 R5 window");
  endtask

  task automatic t_vtab();
    do_reset();
    @(negedge clk);
    vtab_we = 1'b1; vtab_addr = 5'd31; vtab_data = 8'h3C;
    @(negedge clk);
    vtab_we = 1'b1; vtab_addr = 5'd5; vtab_data = 8'h11;
    chk("R9 selected entry written", volt_level, 8'h3C);
    @(negedge clk);
    vtab_we = 1'b0;
    chk("R9 other entry no effect", volt_level, 8'h3C);
    m_vtab[31] = 8'h3C;
    m_vtab[5]  = 8'h11;
    sp = 16'd26; iter = 4'd5;
    for (int i = 0; i < 10; i++) send_frame(6, 0, "R9 after write");
  endtask

  task automatic t_handshake();
    bit smp;
    int lv;
    bit moved;
    do_reset(); sp = 16'd26; iter = 4'd4;
    for (int i = 0; i < 4; i++) send_frame(8, 0, "R2 pre");
    repeat (3) @(negedge clk);
    chk("R2 no start before fifth frame", busy, 0);
    @(negedge clk);
    frame_delay = 16'd8; frame_valid = 1'b1;
    m_frame(8, 0, smp);
    lv = freq_level;
    @(negedge clk);
    frame_valid = 1'b0;
    @(negedge clk);
    chk("R10 busy after trigger", busy, 1);
    moved = 0;
    for (int n = 0; n < 3000 && !level_valid; n++) begin
      if (freq_level != lv) moved = 1;
      @(negedge clk);
    end
    chk("R10 level held while busy", moved, 0);
    chk("R10 valid seen", level_valid, 1);
    chk("R10 busy low with valid", busy, 0);
    chk("R2 R10 level", freq_level, m_level);
    @(negedge clk);
    chk("R10 valid one cycle", level_valid, 0);
  endtask

  initial begin
    m_reset();
    t_reset();
    t_on_target();
    t_light();
    t_clamp();
    t_iter();
    t_diff();
    t_window();
    t_vtab();
    t_handshake();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule